// File: doc/BRIEF.md
# Fractional-Rate Clock Enable Generator

This block derives a one-clock enable strobe from the master clock. The average strobe rate is any fraction `increment / modulus` of the clock rate. The ratio does not have to be an integer. A 230400 Hz serial tick from a 50 MHz clock is one example.

Internally a phase accumulator steps by the increment on every active cycle. Once the accumulator has reached the modulus, the modulus is taken off in the same step. The leftover phase therefore carries forward and the long-run rate is exact, even though the spacing between strobes varies by one cycle.

The increment comes either from a parameter or from a runtime input, chosen by a parameter. When the modulus is a power of two, the wrap test is the carry bit of a plain binary add. A `run` input freezes the phase without losing it. Downstream logic simply qualifies its registers with `tick`.

Top module: `frac_tick_gen`

## Requirements
- R1: While `rst_n` is low, the accumulator is cleared to zero and `tick` is low, independent of the clock. The first clock after release is a normal step from zero.
- R2: `tick` is registered. After k run steps counted from reset (k ≥ 1), the total number of strobes equals floor((k−1)·inc / MODULUS). Each strobe lasts one clock and marks one wrap step.
- R3: On a step, if the accumulator is at or above MODULUS it becomes accumulator + inc − MODULUS and `tick` goes high. Otherwise it becomes accumulator + inc and `tick` goes low. As a result, any N·MODULUS consecutive run steps that begin after the first step hold exactly N·inc strobes.
- R4: Two strobes are never separated by fewer than floor(MODULUS / inc) run steps.
- R5: While `run` is low, the accumulator holds its value and `tick` is low. When `run` returns high, stepping continues from the held phase.
- R6: When inc equals MODULUS, `tick` is high on every run step except the first one after reset.
- R7: With `USE_INC_PORT` = 1, the increment is `inc_in`, zero-extended. Its legal range is 1 to MODULUS. With `USE_INC_PORT` = 0, the increment is the parameter `INC`, and its range is checked at elaboration.
- R8: When MODULUS is a power of two, the wrap test uses the carry bit of the accumulator. The observable behaviour is the same as in R2 to R6.
- R9: The accumulator is one bit wider than MODULUS needs. It never exceeds 2·MODULUS − 1, so no wrap is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Step enable; low freezes the phase |
| inc_in | input | $clog2(MODULUS+1) | Runtime increment, used when USE_INC_PORT = 1 |
| tick | output | 1 | One-clock enable strobe |

## Verification
The bench builds two instances, both taking the increment from `inc_in`. One has a modulus of 100 and uses the compare-and-subtract path. The other has a modulus of 64 and uses the carry path. With moduli this small, whole N·MODULUS windows, the inc = MODULUS and inc = 1 extremes, and long random run/stall patterns all fit into a few thousand cycles. The 50 MHz default configuration is only elaborated.

// File: rtl/frac_tick_pkg.sv
package frac_tick_pkg;

  // Accumulator width: enough for the modulus plus one guard bit.
  function automatic int acc_width(int unsigned modulus);
    return $clog2(modulus) + 1;
  endfunction

  // Width that can hold any increment from 1 to the modulus.
  function automatic int inc_width(int unsigned modulus);
    return $clog2(modulus + 1);
  endfunction

  function automatic bit is_pow2(int unsigned modulus);
    return (modulus != 0) && ((modulus & (modulus - 1)) == 0);
  endfunction

endpackage

// File: rtl/frac_tick_step.sv
// Combinational next-phase logic. Two wrap tests are available and the
// modulus picks one at elaboration.
module frac_tick_step #(
  parameter int unsigned MODULUS = 100,
  parameter int          AW      = 8,
  parameter bit          POW2    = 1'b0
) (
  input  logic [AW-1:0] acc,
  input  logic [AW-1:0] inc,
  output logic          wrap,
  output logic [AW-1:0] nxt
);

  localparam logic [AW-1:0] MOD_V = AW'(MODULUS);

  generate
    if (POW2) begin : g_carry
      // Modulus = 2^(AW-1): the guard bit itself is the wrap flag.
      always_comb begin
        wrap = acc[AW-1];
        nxt  = {1'b0, acc[AW-2:0]} + inc;
      end
    end else begin : g_compare
      always_comb begin
        wrap = (acc >= MOD_V);
        if (wrap) nxt = acc + inc - MOD_V;
        else      nxt = acc + inc;
      end
    end
  endgenerate

endmodule

// File: rtl/frac_tick_accum.sv
// Phase register and strobe register.
module frac_tick_accum #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          wrap,
  input  logic [AW-1:0] nxt,
  output logic [AW-1:0] acc_q,
  output logic          tick
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else if (run) begin
      acc_q <= nxt;
      tick  <= wrap;
    end else begin
      tick  <= 1'b0;
    end
  end

  // A stalled cycle keeps the phase and gives no strobe.
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(acc_q) && !tick));

endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen
  import frac_tick_pkg::*;
#(
  parameter int unsigned MODULUS      = 50_000_000,
  parameter int unsigned INC          = 230_400,
  parameter bit          USE_INC_PORT = 1'b0
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 run,
  input  logic [$clog2(MODULUS+1)-1:0]         inc_in,
  output logic                                 tick
);

  localparam int              AW    = acc_width(MODULUS);
  localparam int              IW    = inc_width(MODULUS);
  localparam bit              POW2  = is_pow2(MODULUS);
  localparam logic [AW-1:0]   MOD_V = AW'(MODULUS);

  logic [IW-1:0] inc_w;
  logic [AW-1:0] inc_ext;
  logic [AW-1:0] acc_q;
  logic [AW-1:0] nxt;
  logic          wrap;

  generate
    if (USE_INC_PORT) begin : g_inc_port
      assign inc_w = inc_in;
    end else begin : g_inc_param
      if (INC < 1 || INC > MODULUS) begin : g_bad_inc
        $error("frac_tick_gen: INC must lie in 1..MODULUS");
      end
      logic unused_inc;
      assign unused_inc = ^inc_in;
      assign inc_w      = IW'(INC);
    end
  endgenerate

  assign inc_ext = AW'(inc_w);

  frac_tick_step #(
    .MODULUS (MODULUS),
    .AW      (AW),
    .POW2    (POW2)
  ) u_step (
    .acc  (acc_q),
    .inc  (inc_ext),
    .wrap (wrap),
    .nxt  (nxt)
  );

  frac_tick_accum #(
    .AW (AW)
  ) u_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .wrap  (wrap),
    .nxt   (nxt),
    .acc_q (acc_q),
    .tick  (tick)
  );

  // Reset leaves a cleared phase and a quiet strobe.
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (!tick && acc_q == '0));

  // A step taken from at or above the modulus strobes on the next cycle.
  assert_wrap_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && acc_q >= MOD_V) |=> tick);

  // A step taken from below the modulus does not strobe.
  assert_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && acc_q < MOD_V) |=> !tick);

  // The increment in use stays in its legal range.
  assert_inc_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (inc_w != '0 && 32'(inc_w) <= MODULUS));

  // The guard bit prevents any wrap from being lost.
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(acc_q) < 2 * MODULUS);

endmodule

// File: tb/frac_tick_gen_bench.sv
module frac_tick_gen_bench;

  localparam int unsigned MOD_A = 100;
  localparam int unsigned MOD_B = 64;

  logic       clk   = 1'b0;
  logic       rst_n = 1'b0;
  logic       run   = 1'b0;
  logic [6:0] inc_a = 7'd1;
  logic [6:0] inc_b = 7'd1;
  logic       tick_a;
  logic       tick_b;

  always #2 clk = ~clk;

  frac_tick_gen #(.MODULUS(MOD_A), .INC(1), .USE_INC_PORT(1'b1)) u_frac_tick_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .inc_in(inc_a), .tick(tick_a));

  frac_tick_gen #(.MODULUS(MOD_B), .INC(1), .USE_INC_PORT(1'b1)) u_frac_tick_gen_pow2 (
    .clk(clk), .rst_n(rst_n), .run(run), .inc_in(inc_b), .tick(tick_b));

  int     checks = 0;
  int     errors = 0;
  bit     done   = 1'b0;
  bit     prev_run;
  bit     win_chk;
  longint k[2], last[2], cnt[2], incv[2], modv[2];

  function automatic longint cum(longint kk, longint i, longint m);
    return (kk < 1) ? 0 : ((kk - 1) * i) / m;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reset_dut(int ia, int ib);
    @(negedge clk);
    rst_n    = 1'b0;
    run      = 1'b0;
    prev_run = 1'b0;
    inc_a    = 7'(ia);
    inc_b    = 7'(ib);
    incv[0]  = ia; incv[1] = ib;
    modv[0]  = MOD_A; modv[1] = MOD_B;
    for (int d = 0; d < 2; d++) begin
      k[d] = 0; last[d] = 0; cnt[d] = 0;
    end
    for (int c = 0; c < 2; c++) begin
      @(negedge clk);
      chk(tick_a == 1'b0, "R1 tick_a in reset", longint'(tick_a), 0);
      chk(tick_b == 1'b0, "R1 tick_b in reset", longint'(tick_b), 0);
    end
    rst_n = 1'b1;
  endtask

  // Check the strobe produced by the previous edge, then drive run.
  task automatic step(bit rn);
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      bit obs;
      bit exp;
      obs = (d == 0) ? tick_a : tick_b;
      if (prev_run) k[d]++;
      exp = prev_run &&
            (cum(k[d], incv[d], modv[d]) - cum(k[d] - 1, incv[d], modv[d]) == 1);
      chk(obs == exp, (d == 0) ? "R2 cumulative strobe" : "R8 carry-path strobe",
          longint'(obs), longint'(exp));
      if (obs) begin
        cnt[d]++;
        if (last[d] > 0)
          chk(k[d] - last[d] >= modv[d] / incv[d], "R4 minimum spacing",
              k[d] - last[d], modv[d] / incv[d]);
        last[d] = k[d];
      end
      if (win_chk && prev_run && k[d] == 3 * modv[d] + 1)
        chk(cnt[d] == 3 * incv[d], "R3 window count", cnt[d], 3 * incv[d]);
    end
    run      = rn;
    prev_run = rn;
  endtask

  initial begin
    longint held_a, held_b;
    void'($urandom(32'd4242));
    win_chk = 1'b0;

    // R6 and R9: increment equal to the modulus.
    reset_dut(MOD_A, MOD_B);
    for (int i = 0; i < 21; i++) step(1'b1);
    chk(cnt[0] == k[0] - 1, "R6/R9 inc==MOD count A", cnt[0], k[0] - 1);
    chk(cnt[1] == k[1] - 1, "R6/R9 inc==MOD count B", cnt[1], k[1] - 1);

    // R3: three full windows with uninterrupted run.
    reset_dut(23, 17);
    win_chk = 1'b1;
    for (int i = 0; i < 3 * MOD_A + 2; i++) step(1'b1);
    win_chk = 1'b0;

    // Smallest increment, so the spacing bound equals the modulus.
    reset_dut(1, 1);
    win_chk = 1'b1;
    for (int i = 0; i < 3 * MOD_A + 2; i++) step(1'b1);
    win_chk = 1'b0;

    // R5: a stall keeps the phase, and counting resumes from it.
    reset_dut(37, 29);
    for (int i = 0; i < 60; i++) step(1'b1);
    held_a = cnt[0]; held_b = cnt[1];
    for (int i = 0; i < 40; i++) step(1'b0);
    chk(cnt[0] == held_a, "R5 no strobe while held A", cnt[0], held_a);
    chk(cnt[1] == held_b, "R5 no strobe while held B", cnt[1], held_b);
    for (int i = 0; i < 200; i++) step(1'b1);

    // R7: random runtime increments with random stalls.
    for (int t = 0; t < 6; t++) begin
      reset_dut(1 + int'($urandom % MOD_A), 1 + int'($urandom % MOD_B));
      for (int i = 0; i < 1500; i++) step(($urandom % 4) != 0);
    end

    // R1: a reset in the middle of a run.
    reset_dut(99, 63);
    for (int i = 0; i < 50; i++) step(1'b1);
    reset_dut(99, 63);
    for (int i = 0; i < 3; i++) step(1'b1);
    chk(cnt[0] == 0, "R1 restart from zero", cnt[0], 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule